// File: doc/BRIEF.md
# Instruction Group Dependency Checker

This block watches a stream of decoded instructions, one per clock, and enforces the rules of an explicitly parallel instruction group. Each instruction carries up to one general register destination, two general register sources, two predicate destinations, one qualifying predicate source, one branch register destination and one branch register source. It also carries a class tag, a parallel-compare type and a stop flag. An instruction group runs from the instruction after one stop up to and including the next instruction that carries a stop. Inside a group the instructions are meant to be independent. The checker records which registers have already been written in the open group, and raises an error when a later instruction in the group breaks the rules.

The general, predicate and branch spaces each have their own written-register map. The predicate map also keeps the parallel-compare type of the first writer of each predicate. Errors come out one clock after the offending instruction as a single-cycle pulse. The pulse carries a cause vector and the position of the instruction inside its group. The checker sits beside a decode stage. It never stalls anything, and a violation is reported but does not change what is recorded.

A small sequencer with two states runs the group position. In `GRP_IDLE` no instruction of the current group has been seen yet, so the position is 0. In `GRP_OPEN` at least one instruction has been seen, and the position counts up and saturates. The sequencer has four transitions:
- *open*: IDLE to OPEN, on a valid instruction without a stop.
- *solo*: IDLE to IDLE, on a valid instruction with a stop.
- *extend*: OPEN to OPEN, on a valid instruction without a stop.
- *close*: OPEN to IDLE, on a valid instruction with a stop.

Top module: `insn_group_checker`

## Requirements
- R1: The stop carried by a valid instruction clears all recorded writes after that instruction has been checked, so the next instruction may read or write any register without error.
- R2: A write to a general or branch register already written earlier in the same group sets cause bit 1 (write conflict).
- R3: Reading a register and then writing it later in the same group raises no error.
- R4: A read, by a non-branch instruction, of a general, predicate or branch register written earlier in the same group sets cause bit 0 (read conflict). A general register read sets cause bit 0 for any class unless R6 applies.
- R5: An instruction of class branch (`in_kind` = 1) may read predicate and branch registers written earlier in the group without error. Its general register reads still follow R4.
- R6: A general register whose first in-group writer was a successful checked load (`in_kind` = 2) may be read later in the group without error.
- R7: Parallel compare types are encoded as 1 = and, 2 = and-complement, 3 = or, 4 = or-complement, and 0 = ordinary write. A repeated write to a predicate raises no error when both the earlier and the new writer use the same nonzero type. Two different nonzero types set cause bit 2 (compare mix). If either writer is ordinary, cause bit 1 is set.
- R8: Writes to register 0 of any space are never recorded, so register 0 never causes a conflict.
- R9: `err_valid` is high for exactly the clock after a valid instruction that breaks a rule. It is never set after a cycle with `in_valid` low, and an invalid cycle records nothing and neither opens nor closes a group.
- R10: After reset no error is signalled, the cause and position read 0, and nothing is recorded, even if reset arrives in the middle of a group.
- R11: `err_slot` gives the 0-based position of the instruction within its group. The position saturates at 15 for long groups and restarts at 0 after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_stop | input | 1 | This instruction ends its group |
| in_kind | input | 2 | Class: 0 plain, 1 branch, 2 successful checked load |
| in_cmp | input | 3 | Parallel-compare type of the predicate writes |
| gr_dst_en | input | 1 | General destination present |
| gr_dst | input | 7 | General destination index |
| gr_src0_en | input | 1 | First general source present |
| gr_src0 | input | 7 | First general source index |
| gr_src1_en | input | 1 | Second general source present |
| gr_src1 | input | 7 | Second general source index |
| pr_dst0_en | input | 1 | First predicate destination present |
| pr_dst0 | input | 6 | First predicate destination index |
| pr_dst1_en | input | 1 | Second predicate destination present |
| pr_dst1 | input | 6 | Second predicate destination index |
| pr_src_en | input | 1 | Qualifying predicate read present |
| pr_src | input | 6 | Qualifying predicate index |
| br_dst_en | input | 1 | Branch register destination present |
| br_dst | input | 3 | Branch register destination index |
| br_src_en | input | 1 | Branch register source present |
| br_src | input | 3 | Branch register source index |
| err_valid | output | 1 | One-cycle violation pulse |
| err_cause | output | 3 | Bit 0 read conflict, bit 1 write conflict, bit 2 compare mix |
| err_slot | output | 4 | Position of the instruction in its group |

## Verification
All three outputs are due exactly one clock after the instruction is presented. The bench drives each instruction on a falling edge and compares the full triple of valid, cause and position on the next falling edge. That comparison includes the error-free instructions, so a wrong position or a stray cause is caught as well. To check that the pulse lasts one cycle, an idle cycle follows an offending instruction and `err_valid` is sampled low one falling edge later. Tests that depend on reset or on invalid cycles place their probing instruction directly after that event, so the result seen is the first one the design can produce.

// File: rtl/igc_pkg.sv
package igc_pkg;

    typedef enum logic [1:0] {
        KIND_PLAIN  = 2'd0,
        KIND_BRANCH = 2'd1,
        KIND_CHKLD  = 2'd2
    } ikind_e;

    typedef enum logic [2:0] {
        PC_NONE  = 3'd0,
        PC_AND   = 3'd1,
        PC_ANDCM = 3'd2,
        PC_OR    = 3'd3,
        PC_ORCM  = 3'd4
    } pcmp_e;

    typedef enum logic {
        GRP_IDLE = 1'b0,
        GRP_OPEN = 1'b1
    } grp_state_e;

    localparam int CAUSE_W   = 3;
    localparam int CAUSE_RAW = 0;
    localparam int CAUSE_WAW = 1;
    localparam int CAUSE_MIX = 2;

endpackage

// File: rtl/igc_reg_track.sv
module igc_reg_track #(
    parameter  int NREG = 128,
    parameter  int NRD  = 2,
    localparam int IW   = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic                   wr_flag,
    input  logic [NRD-1:0][IW-1:0] rd_idx,
    output logic [NRD-1:0]         rd_hit,
    output logic [NRD-1:0]         rd_flag,
    output logic                   wr_hit
);

    logic [NREG-1:0] written;
    logic [NREG-1:0] exempt;

    always_comb begin
        for (int r = 0; r < NRD; r++) begin
            rd_hit[r]  = written[rd_idx[r]];
            rd_flag[r] = exempt[rd_idx[r]];
        end
        wr_hit = written[wr_idx];
    end

    // First writer wins; index 0 is never recorded.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            written <= '0;
            exempt  <= '0;
        end else if (clear) begin
            written <= '0;
            exempt  <= '0;
        end else if (wr_en && (wr_idx != '0) && !written[wr_idx]) begin
            written[wr_idx] <= 1'b1;
            exempt[wr_idx]  <= wr_flag;
        end
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (written == '0)); // R1

    AST_ZERO_UNTRACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |=> !written[0]); // R8

    AST_FIRST_WRITER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && wr_en && wr_hit) |=> ($stable(written) && $stable(exempt))); // R2

endmodule

// File: rtl/igc_pred_track.sv
module igc_pred_track
    import igc_pkg::*;
#(
    parameter  int NPRED = 64,
    localparam int IW    = $clog2(NPRED)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic [1:0]           wr_en,
    input  logic [1:0][IW-1:0]   wr_idx,
    input  pcmp_e                wr_type,
    input  logic [IW-1:0]        rd_idx,
    output logic                 rd_hit,
    output logic [1:0]           wr_hit,
    output pcmp_e [1:0]          old_type
);

    logic  written [NPRED];
    pcmp_e ptype   [NPRED];

    for (genvar i = 0; i < NPRED; i++) begin : g_pred
        if (i == 0) begin : g_zero
            assign written[i] = 1'b0;
            assign ptype[i]   = PC_NONE;
        end else begin : g_live
            logic set_now;
            assign set_now = (wr_en[0] && wr_idx[0] == IW'(i)) ||
                             (wr_en[1] && wr_idx[1] == IW'(i));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    written[i] <= 1'b0;
                    ptype[i]   <= PC_NONE;
                end else if (clear) begin
                    written[i] <= 1'b0;
                    ptype[i]   <= PC_NONE;
                end else if (set_now && !written[i]) begin
                    written[i] <= 1'b1;
                    ptype[i]   <= wr_type;
                end
            end
        end
    end

    always_comb begin
        rd_hit = written[rd_idx];
        for (int k = 0; k < 2; k++) begin
            wr_hit[k]   = written[wr_idx[k]];
            old_type[k] = ptype[wr_idx[k]];
        end
    end

    AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && wr_en[0] && wr_hit[0]) |=> (ptype[$past(wr_idx[0])] == $past(old_type[0]))); // R7

    AST_PRED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && wr_en[0]) |=> !written[$past(wr_idx[0])]); // R1

endmodule

// File: rtl/igc_group_fsm.sv
module igc_group_fsm
    import igc_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_stop,
    output logic [SLOT_W-1:0] slot,
    output logic              grp_clear
);

    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

    grp_state_e        state, state_nxt;
    logic [SLOT_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GRP_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        grp_clear = in_valid && in_stop;
        state_nxt = state;
        cnt_nxt   = cnt;
        slot      = '0;
        unique case (state)
            GRP_IDLE: begin
                slot = '0;
                if (in_valid && !in_stop) begin      // open
                    state_nxt = GRP_OPEN;
                    cnt_nxt   = SLOT_W'(1);
                end else begin                       // solo or no instruction
                    cnt_nxt   = '0;
                end
            end
            GRP_OPEN: begin
                slot = cnt;
                if (in_valid && in_stop) begin       // close
                    state_nxt = GRP_IDLE;
                    cnt_nxt   = '0;
                end else if (in_valid) begin         // extend
                    cnt_nxt = (cnt == SLOT_MAX) ? cnt : cnt + SLOT_W'(1);
                end
            end
        endcase
    end

    AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_stop) |=> (slot == '0)); // R11

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_stop && slot != SLOT_MAX) |=> (slot == $past(slot) + SLOT_W'(1))); // R11

    AST_SLOT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(slot)); // R9

endmodule

// File: rtl/insn_group_checker.sv
module insn_group_checker
    import igc_pkg::*;
#(
    parameter  int NGR    = 128,
    parameter  int NPR    = 64,
    parameter  int NBR    = 8,
    parameter  int SLOT_W = 4,
    localparam int GW     = $clog2(NGR),
    localparam int PW     = $clog2(NPR),
    localparam int BW     = $clog2(NBR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_stop,
    input  logic [1:0]         in_kind,
    input  logic [2:0]         in_cmp,
    input  logic               gr_dst_en,
    input  logic [GW-1:0]      gr_dst,
    input  logic               gr_src0_en,
    input  logic [GW-1:0]      gr_src0,
    input  logic               gr_src1_en,
    input  logic [GW-1:0]      gr_src1,
    input  logic               pr_dst0_en,
    input  logic [PW-1:0]      pr_dst0,
    input  logic               pr_dst1_en,
    input  logic [PW-1:0]      pr_dst1,
    input  logic               pr_src_en,
    input  logic [PW-1:0]      pr_src,
    input  logic               br_dst_en,
    input  logic [BW-1:0]      br_dst,
    input  logic               br_src_en,
    input  logic [BW-1:0]      br_src,
    output logic               err_valid,
    output logic [CAUSE_W-1:0] err_cause,
    output logic [SLOT_W-1:0]  err_slot
);

    ikind_e kind;
    pcmp_e  cmp;
    logic   is_branch;
    assign kind      = ikind_e'(in_kind);
    assign cmp       = pcmp_e'(in_cmp);
    assign is_branch = (kind == KIND_BRANCH);

    logic [SLOT_W-1:0] slot;
    logic              grp_clear;

    igc_group_fsm #(.SLOT_W(SLOT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_stop   (in_stop),
        .slot      (slot),
        .grp_clear (grp_clear)
    );

    logic [1:0] gr_rd_hit, gr_rd_flag;
    logic       gr_wr_hit;

    igc_reg_track #(.NREG(NGR), .NRD(2)) u_gr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (grp_clear),
        .wr_en   (in_valid && gr_dst_en),
        .wr_idx  (gr_dst),
        .wr_flag (kind == KIND_CHKLD),
        .rd_idx  ({gr_src1, gr_src0}),
        .rd_hit  (gr_rd_hit),
        .rd_flag (gr_rd_flag),
        .wr_hit  (gr_wr_hit)
    );

    logic [0:0] br_rd_hit, br_rd_flag;
    logic       br_wr_hit;

    igc_reg_track #(.NREG(NBR), .NRD(1)) u_br (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (grp_clear),
        .wr_en   (in_valid && br_dst_en),
        .wr_idx  (br_dst),
        .wr_flag (1'b0),
        .rd_idx  (br_src),
        .rd_hit  (br_rd_hit),
        .rd_flag (br_rd_flag),
        .wr_hit  (br_wr_hit)
    );

    logic        pr_rd_hit;
    logic [1:0]  pr_wr_hit;
    pcmp_e [1:0] pr_old;
    logic [1:0]  pr_en;

    assign pr_en = {pr_dst1_en, pr_dst0_en};

    igc_pred_track #(.NPRED(NPR)) u_pr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (grp_clear),
        .wr_en    ({2{in_valid}} & pr_en),
        .wr_idx   ({pr_dst1, pr_dst0}),
        .wr_type  (cmp),
        .rd_idx   (pr_src),
        .rd_hit   (pr_rd_hit),
        .wr_hit   (pr_wr_hit),
        .old_type (pr_old)
    );

    logic [CAUSE_W-1:0] cause;

    always_comb begin
        cause = '0;
        // read conflicts
        for (int r = 0; r < 2; r++) begin
            if ((r == 0 ? gr_src0_en : gr_src1_en) && gr_rd_hit[r] && !gr_rd_flag[r])
                cause[CAUSE_RAW] = 1'b1;
        end
        if (!is_branch && pr_src_en && pr_rd_hit)
            cause[CAUSE_RAW] = 1'b1;
        if (!is_branch && br_src_en && br_rd_hit[0] && !br_rd_flag[0])
            cause[CAUSE_RAW] = 1'b1;
        // write conflicts
        if (gr_dst_en && gr_wr_hit)
            cause[CAUSE_WAW] = 1'b1;
        if (br_dst_en && br_wr_hit)
            cause[CAUSE_WAW] = 1'b1;
        for (int k = 0; k < 2; k++) begin
            if (pr_en[k] && pr_wr_hit[k]) begin
                if (cmp == PC_NONE || pr_old[k] == PC_NONE)
                    cause[CAUSE_WAW] = 1'b1;
                else if (pr_old[k] != cmp)
                    cause[CAUSE_MIX] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_cause <= '0;
            err_slot  <= '0;
        end else begin
            err_valid <= in_valid && (cause != '0);
            err_cause <= in_valid ? cause : '0;
            if (in_valid)
                err_slot <= slot;
        end
    end

    AST_NO_ERR_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !err_valid); // R9

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(in_valid)); // R9

    AST_STOP_THEN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_stop) |=> (!(gr_src0_en && gr_rd_hit[0]) && !(pr_src_en && pr_rd_hit))); // R1

endmodule

// File: tb/insn_group_checker_test.sv
module insn_group_checker_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0] req;
        logic       stop;
        logic [1:0] kind;
        logic [2:0] cmp;
        logic       gde;  logic [6:0] gd;
        logic       s0e;  logic [6:0] s0;
        logic       s1e;  logic [6:0] s1;
        logic       p0e;  logic [5:0] p0;
        logic       p1e;  logic [5:0] p1;
        logic       pse;  logic [5:0] ps;
        logic       bde;  logic [2:0] bd;
        logic       bse;  logic [2:0] bs;
        logic [2:0] ecause;
        logic [3:0] eslot;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{4'd3,1'b0,2'd0,3'd0, 1'b1,7'd5,  1'b0,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd0}, // R3 write g5
        '{4'd4,1'b0,2'd0,3'd0, 1'b0,7'd0,  1'b1,7'd5,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd1,4'd1}, // R4 read g5
        '{4'd3,1'b0,2'd0,3'd0, 1'b0,7'd0,  1'b1,7'd7,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd2}, // R3 read g7
        '{4'd3,1'b0,2'd0,3'd0, 1'b1,7'd7,  1'b0,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd3}, // R3 write g7 after read
        '{4'd2,1'b1,2'd0,3'd0, 1'b1,7'd5,  1'b0,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd2,4'd4}, // R2 rewrite g5, stop
        '{4'd1,1'b0,2'd0,3'd0, 1'b0,7'd0,  1'b1,7'd5,  1'b1,7'd7, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd0}, // R1 new group
        '{4'd4,1'b0,2'd0,3'd0, 1'b0,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b1,6'd3, 1'b1,6'd4, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd1}, // R4 write p3 p4
        '{4'd5,1'b0,2'd1,3'd0, 1'b0,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b1,6'd3, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd2}, // R5 branch on p3
        '{4'd5,1'b0,2'd0,3'd0, 1'b0,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b1,3'd2, 1'b0,3'd0, 3'd0,4'd3}, // R5 write b2
        '{4'd5,1'b0,2'd1,3'd0, 1'b0,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b1,6'd4, 1'b0,3'd0, 1'b1,3'd2, 3'd0,4'd4}, // R5 branch via b2
        '{4'd4,1'b0,2'd0,3'd0, 1'b0,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b1,6'd3, 1'b0,3'd0, 1'b0,3'd0, 3'd1,4'd5}, // R4 plain reads p3
        '{4'd4,1'b1,2'd0,3'd0, 1'b0,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b1,3'd2, 3'd1,4'd6}, // R4 plain reads b2, stop
        '{4'd6,1'b0,2'd2,3'd0, 1'b1,7'd9,  1'b0,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd0}, // R6 checked load g9
        '{4'd6,1'b0,2'd0,3'd0, 1'b0,7'd0,  1'b1,7'd9,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd1}, // R6 consume g9
        '{4'd5,1'b0,2'd0,3'd0, 1'b1,7'd10, 1'b0,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd2}, // R5 write g10
        '{4'd5,1'b0,2'd1,3'd0, 1'b0,7'd0,  1'b0,7'd0,  1'b1,7'd10,1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd1,4'd3}, // R5 branch reads g10
        '{4'd8,1'b0,2'd0,3'd0, 1'b1,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b1,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b1,3'd0, 1'b0,3'd0, 3'd0,4'd4}, // R8 write reg 0s
        '{4'd8,1'b0,2'd0,3'd0, 1'b1,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b1,6'd0, 1'b0,6'd0, 1'b1,3'd0, 1'b0,3'd0, 3'd0,4'd5}, // R8 again
        '{4'd8,1'b1,2'd0,3'd0, 1'b0,7'd0,  1'b1,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b1,6'd0, 1'b0,3'd0, 1'b1,3'd0, 3'd0,4'd6}, // R8 read reg 0s, stop
        '{4'd7,1'b0,2'd0,3'd1, 1'b0,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b1,6'd10,1'b1,6'd11,1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd0}, // R7 and p10 p11
        '{4'd7,1'b0,2'd0,3'd1, 1'b0,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b1,6'd10,1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd1}, // R7 and again p10
        '{4'd7,1'b0,2'd0,3'd3, 1'b0,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b1,6'd11,1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd4,4'd2}, // R7 or on p11: mix
        '{4'd7,1'b0,2'd0,3'd0, 1'b0,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b1,6'd10,1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd2,4'd3}, // R7 ordinary on p10
        '{4'd7,1'b0,2'd0,3'd0, 1'b0,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b1,6'd12,1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd4}, // R7 ordinary p12
        '{4'd7,1'b1,2'd0,3'd4, 1'b0,7'd0,  1'b0,7'd0,  1'b0,7'd0, 1'b1,6'd12,1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd2,4'd5}, // R7 or-compl on p12, stop
        '{4'd2,1'b0,2'd0,3'd0, 1'b1,7'd20, 1'b0,7'd0,  1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd0,4'd0}, // R2 write g20
        '{4'd2,1'b1,2'd0,3'd0, 1'b1,7'd20, 1'b1,7'd20, 1'b0,7'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0, 1'b0,3'd0, 3'd3,4'd1}  // R2 R4 both causes
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid, in_stop;
    logic [1:0] in_kind;
    logic [2:0] in_cmp;
    logic       gr_dst_en, gr_src0_en, gr_src1_en;
    logic [6:0] gr_dst, gr_src0, gr_src1;
    logic       pr_dst0_en, pr_dst1_en, pr_src_en;
    logic [5:0] pr_dst0, pr_dst1, pr_src;
    logic       br_dst_en, br_src_en;
    logic [2:0] br_dst, br_src;
    logic       err_valid;
    logic [2:0] err_cause;
    logic [3:0] err_slot;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_group_checker uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_stop(in_stop),
        .in_kind(in_kind), .in_cmp(in_cmp),
        .gr_dst_en(gr_dst_en), .gr_dst(gr_dst),
        .gr_src0_en(gr_src0_en), .gr_src0(gr_src0),
        .gr_src1_en(gr_src1_en), .gr_src1(gr_src1),
        .pr_dst0_en(pr_dst0_en), .pr_dst0(pr_dst0),
        .pr_dst1_en(pr_dst1_en), .pr_dst1(pr_dst1),
        .pr_src_en(pr_src_en), .pr_src(pr_src),
        .br_dst_en(br_dst_en), .br_dst(br_dst),
        .br_src_en(br_src_en), .br_src(br_src),
        .err_valid(err_valid), .err_cause(err_cause), .err_slot(err_slot)
    );

    function automatic vec_t blank(int req);
        vec_t v = '0;
        v.req = 4'(req);
        return v;
    endfunction

    task automatic apply(vec_t v, logic valid);
        in_valid   = valid;      in_stop    = v.stop;
        in_kind    = v.kind;     in_cmp     = v.cmp;
        gr_dst_en  = v.gde;      gr_dst     = v.gd;
        gr_src0_en = v.s0e;      gr_src0    = v.s0;
        gr_src1_en = v.s1e;      gr_src1    = v.s1;
        pr_dst0_en = v.p0e;      pr_dst0    = v.p0;
        pr_dst1_en = v.p1e;      pr_dst1    = v.p1;
        pr_src_en  = v.pse;      pr_src     = v.ps;
        br_dst_en  = v.bde;      br_dst     = v.bd;
        br_src_en  = v.bse;      br_src     = v.bs;
    endtask

    task automatic compare(int req, logic ev, logic [2:0] ec, logic [3:0] es);
        n_chk++;
        if (err_valid !== ev || err_cause !== ec || err_slot !== es) begin
            n_fail++;
            $display("FAIL R%0d: got valid=%b cause=%b slot=%0d, expected valid=%b cause=%b slot=%0d",
                     req, err_valid, err_cause, err_slot, ev, ec, es);
        end
    endtask

    task automatic check_valid(int req, logic ev);
        n_chk++;
        if (err_valid !== ev) begin
            n_fail++;
            $display("FAIL R%0d: got err_valid=%b, expected %b", req, err_valid, ev);
        end
    endtask

    // present at a falling edge, result due at the next falling edge
    task automatic step(vec_t v);
        apply(v, 1'b1);
        @(negedge clk);
        compare(int'(v.req), v.ecause != 3'd0, v.ecause, v.eslot);
    endtask

    task automatic idle_cycle();
        apply(blank(0), 1'b0);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R9: watchdog expired, got hung run, expected completion");
        summary();
        $finish;
    end

    initial begin
        vec_t v;
        apply(blank(0), 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(10, 1'b0, 3'd0, 4'd0); // R10 reset state

        for (int i = 0; i < NV; i++) step(VEC[i]);

        // R9: pulse lasts one cycle
        v = blank(9); v.gde = 1'b1; v.gd = 7'd30; step(v);
        v.ecause = 3'd2; v.eslot = 4'd1; step(v);
        idle_cycle();
        check_valid(9, 1'b0);
        v = blank(9); v.stop = 1'b1; v.eslot = 4'd2; step(v);

        // R9: invalid cycle records nothing and does not close the group
        v = blank(9); v.gde = 1'b1; v.gd = 7'd40; step(v);
        v = blank(9); v.gde = 1'b1; v.gd = 7'd41; v.stop = 1'b1;
        apply(v, 1'b0);
        @(negedge clk);
        check_valid(9, 1'b0);
        v = blank(9); v.gde = 1'b1; v.gd = 7'd41; v.eslot = 4'd1; step(v);
        v = blank(9); v.s0e = 1'b1; v.s0 = 7'd40; v.stop = 1'b1;
        v.ecause = 3'd1; v.eslot = 4'd2; step(v);

        // R11: position saturates at 15
        for (int i = 0; i < 18; i++) begin
            v = blank(11); v.gde = 1'b1; v.gd = 7'(50 + i);
            v.eslot = (i > 15) ? 4'd15 : 4'(i);
            step(v);
        end
        v = blank(11); v.gde = 1'b1; v.gd = 7'd50; v.stop = 1'b1;
        v.ecause = 3'd2; v.eslot = 4'd15; step(v);
        v = blank(11); v.s0e = 1'b1; v.s0 = 7'd50; step(v);
        v = blank(11); v.stop = 1'b1; v.eslot = 4'd1; step(v);

        // R10: reset in the middle of a group
        v = blank(10); v.gde = 1'b1; v.gd = 7'd60; step(v);
        idle_cycle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        compare(10, 1'b0, 3'd0, 4'd0);
        v = blank(10); v.s0e = 1'b1; v.s0 = 7'd60; step(v);

        idle_cycle();
        summary();
        $finish;
    end

endmodule